// File: doc/BRIEF.md
# Bus Claim Window Controller

This block sits beside a processor bus and watches for transfer starts aimed at the legacy motherboard address space. When such a start is seen, it asks the motherboard to begin the access and opens a short claim window, counted in bus clock cycles. During that window an expansion card on the processor slot may claim the transfer by ending it itself. The card can end it with an acknowledge, an error acknowledge or both together, which means retry. A claim inside the window cancels the motherboard access that was already launched.

If no card claims the transfer by the end of the sixth cycle, the motherboard access is committed from the rising edge that opens the seventh cycle, and it can no longer be stopped. On a committed read the block enables the drivers that put motherboard data onto the processor bus. The motherboard's own acknowledge then ends the transfer, and the block is ready for a new start on the following cycle. Card responses that arrive after the window has closed are ignored.

Top module: `bus_claim_window`

## Requirements
- R1: A transfer start sampled while idle with address bits [31:24] equal to 0x00 or 0xFF raises `mb_start` for exactly one cycle, the cycle after the sampling edge.
- R2: A transfer start whose address bits [31:24] are neither 0x00 nor 0xFF leaves every output low, and card responses after it have no effect.
- R3: A card response sampled on any of the first six edges after the start edge gives a one-cycle `mb_cancel` pulse in the following cycle, and the transfer is not committed.
- R4: `card_ack_n` low alone, `card_err_n` low alone, and both low together (retry) each count as a card response and cancel in the same way.
- R5: If no card response is sampled up to and including the sixth edge after the start, `mb_commit` is high from the seventh cycle on. A response on the sixth edge wins over commit.
- R6: `mb_drive_en` is high together with `mb_commit` when the start was sampled with `rd_nwr` = 1 (read), and stays low for writes (`rd_nwr` = 0).
- R7: Card responses sampled while the transfer is committed are ignored: no `mb_cancel`, and `mb_commit` stays high.
- R8: `mb_ack_n` low sampled while committed clears `mb_commit` and `mb_drive_en` in the next cycle.
- R9: After a cancel or a motherboard acknowledge, a legacy-space start on the very next edge is accepted.
- R10: A transfer start sampled while a transfer is still in its window or committed is ignored and does not raise `mb_start`.
- R11: While `rst_n` is low at a clock edge, all outputs go low and the block returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and processor clock |
| rst_n | input | 1 | Synchronous reset, active low |
| xfer_start | input | 1 | Transfer-start strobe, active high |
| addr | input | 32 | Processor address bus |
| rd_nwr | input | 1 | 1 = read, 0 = write |
| card_ack_n | input | 1 | Card transfer acknowledge, active low |
| card_err_n | input | 1 | Card error acknowledge, active low |
| mb_ack_n | input | 1 | Motherboard transfer acknowledge, active low |
| mb_start | output | 1 | Request to begin the motherboard access |
| mb_cancel | output | 1 | Pulse that withdraws the motherboard access |
| mb_commit | output | 1 | Motherboard access is committed |
| mb_drive_en | output | 1 | Enable for the motherboard-to-processor data drivers |

## Verification
The two functions that can fall in the same cycle are the card claim and the window closing: a card response sampled on the sixth edge arrives on the very edge where the counter would otherwise commit. The bench sweeps the response cycle from the first to the ninth, for reads and writes and for all three response encodings, so the sixth and seventh edges are both hit. It judges the collision by requiring a cancel pulse with commit and driver enable low on the sixth, and commit held with no cancel on any later one.

// File: rtl/bcw_pkg.sv
// Package: shared types for the bus claim window controller.
// Assumes nothing beyond IEEE 1800-2017 enumerations.
package bcw_pkg;

    // Phase of the transfer currently being tracked.
    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_WINDOW = 2'd1,
        PH_COMMIT = 2'd2
    } phase_t;

    // Kind of response a card gave on the processor bus.
    typedef enum logic [1:0] {
        RSP_NONE  = 2'd0,
        RSP_ACK   = 2'd1,
        RSP_ERR   = 2'd2,
        RSP_RETRY = 2'd3
    } card_rsp_t;

endpackage

// File: rtl/bcw_space_decode.sv
// Module: bcw_space_decode
// Tells whether the top address field selects the legacy motherboard space.
// Assumes the legacy space is exactly the low page and the high page of the
// top field; both page values are parameters.
module bcw_space_decode #(
    parameter int          PAGE_W  = 8,
    parameter logic [7:0]  LO_PAGE = 8'h00,
    parameter logic [7:0]  HI_PAGE = 8'hFF
) (
    input  logic [PAGE_W-1:0] page,
    output logic              in_legacy
);
    localparam logic [PAGE_W-1:0] LO_V = PAGE_W'(LO_PAGE);
    localparam logic [PAGE_W-1:0] HI_V = PAGE_W'(HI_PAGE);

    // Compare the page field against both legacy pages.
    always_comb begin
        in_legacy = (page == LO_V) || (page == HI_V);
    end
endmodule

// File: rtl/bcw_rsp_classify.sv
// Module: bcw_rsp_classify
// Turns the card's two active-low termination lines into one response kind.
// Assumes the lines are already synchronous to the bus clock.
module bcw_rsp_classify
    import bcw_pkg::*;
(
    input  logic      ack_n,
    input  logic      err_n,
    output card_rsp_t rsp
);
    // Both low is a retry; one low alone is an ack or an error.
    always_comb begin
        unique case ({~err_n, ~ack_n})
            2'b01:   rsp = RSP_ACK;
            2'b10:   rsp = RSP_ERR;
            2'b11:   rsp = RSP_RETRY;
            default: rsp = RSP_NONE;
        endcase
    end
endmodule

// File: rtl/bcw_window_fsm.sv
// Module: bcw_window_fsm
// Tracks one transfer: opens the claim window on a legacy start, counts its
// cycles, cancels on a card response inside it and commits when it closes.
// Assumes one outstanding transfer at a time; starts seen while busy are
// dropped. The motherboard acknowledge is only honoured once committed.
module bcw_window_fsm
    import bcw_pkg::*;
#(
    parameter int WINDOW_CYC = 6
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      start_hit,
    input  logic      rd_nwr,
    input  card_rsp_t card_rsp,
    input  logic      mb_ack_n,
    output logic      mb_start,
    output logic      mb_cancel,
    output logic      mb_commit,
    output logic      mb_drive_en
);
    localparam int             CNT_W   = $clog2(WINDOW_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WINDOW_CYC);

    phase_t             phase;
    logic [CNT_W-1:0]   cyc_cnt;
    logic               rd_q;
    logic               claimed;

    // A card response of any kind claims the transfer.
    always_comb begin
        claimed = (card_rsp != RSP_NONE);
    end

    // Phase, window counter and registered outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase       <= PH_IDLE;
            cyc_cnt     <= '0;
            rd_q        <= 1'b0;
            mb_start    <= 1'b0;
            mb_cancel   <= 1'b0;
            mb_commit   <= 1'b0;
            mb_drive_en <= 1'b0;
        end else begin
            mb_start  <= 1'b0;
            mb_cancel <= 1'b0;
            unique case (phase)
                PH_IDLE: begin
                    if (start_hit) begin
                        phase    <= PH_WINDOW;
                        cyc_cnt  <= CNT_ONE;
                        rd_q     <= rd_nwr;
                        mb_start <= 1'b1;
                    end
                end
                PH_WINDOW: begin
                    if (claimed) begin
                        phase     <= PH_IDLE;
                        cyc_cnt   <= '0;
                        mb_cancel <= 1'b1;
                    end else if (cyc_cnt == CNT_LAST) begin
                        phase       <= PH_COMMIT;
                        cyc_cnt     <= '0;
                        mb_commit   <= 1'b1;
                        mb_drive_en <= rd_q;
                    end else begin
                        cyc_cnt <= cyc_cnt + CNT_ONE;
                    end
                end
                PH_COMMIT: begin
                    if (!mb_ack_n) begin
                        phase       <= PH_IDLE;
                        mb_commit   <= 1'b0;
                        mb_drive_en <= 1'b0;
                    end
                end
                default: begin
                    phase <= PH_IDLE;
                end
            endcase
        end
    end

    AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        mb_start |=> !mb_start); // R1
    AST_BUSY_START_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (start_hit && phase != PH_IDLE) |=> !mb_start); // R10
    AST_CANCEL_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        mb_cancel |=> !mb_cancel); // R3
    AST_COUNT_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_cnt <= CNT_LAST); // R3
    AST_CANCEL_XOR_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        !(mb_cancel && mb_commit)); // R5
    AST_DRIVE_NEEDS_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        mb_drive_en |-> mb_commit); // R6
    AST_COMMIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (mb_commit && mb_ack_n) |=> (mb_commit && !mb_cancel)); // R7
    AST_MB_ACK_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (mb_commit && !mb_ack_n) |=> (!mb_commit && !mb_drive_en)); // R8
endmodule

// File: rtl/bus_claim_window.sv
// Module: bus_claim_window (top)
// Watches processor transfer starts, launches legacy motherboard accesses
// and lets a card claim them inside a fixed cycle window.
// Assumes all inputs are synchronous to clk and at most one transfer is open.
module bus_claim_window #(
    parameter int         ADDR_W     = 32,
    parameter int         PAGE_W     = 8,
    parameter logic [7:0] LO_PAGE    = 8'h00,
    parameter logic [7:0] HI_PAGE    = 8'hFF,
    parameter int         WINDOW_CYC = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              xfer_start,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd_nwr,
    input  logic              card_ack_n,
    input  logic              card_err_n,
    input  logic              mb_ack_n,
    output logic              mb_start,
    output logic              mb_cancel,
    output logic              mb_commit,
    output logic              mb_drive_en
);
    import bcw_pkg::*;

    localparam int PAGE_LSB = ADDR_W - PAGE_W;

    logic      in_legacy;
    logic      start_hit;
    card_rsp_t card_rsp;
    logic      unused_low;

    // Only the page field is decoded; the rest of the address is not needed.
    always_comb begin
        unused_low = ^addr[PAGE_LSB-1:0];
    end

    bcw_space_decode #(
        .PAGE_W  (PAGE_W),
        .LO_PAGE (LO_PAGE),
        .HI_PAGE (HI_PAGE)
    ) u_decode (
        .page      (addr[ADDR_W-1:PAGE_LSB]),
        .in_legacy (in_legacy)
    );

    // Qualify the strobe with the address space.
    always_comb begin
        start_hit = xfer_start && in_legacy;
    end

    bcw_rsp_classify u_rsp (
        .ack_n (card_ack_n),
        .err_n (card_err_n),
        .rsp   (card_rsp)
    );

    bcw_window_fsm #(
        .WINDOW_CYC (WINDOW_CYC)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_hit   (start_hit),
        .rd_nwr      (rd_nwr),
        .card_rsp    (card_rsp),
        .mb_ack_n    (mb_ack_n),
        .mb_start    (mb_start),
        .mb_cancel   (mb_cancel),
        .mb_commit   (mb_commit),
        .mb_drive_en (mb_drive_en)
    );

    AST_FOREIGN_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_start && !in_legacy && !mb_start && !mb_cancel && !mb_commit)
        |=> !mb_start); // R2
endmodule

// File: tb/sim_bus_claim_window.sv
module sim_bus_claim_window;
    localparam int WIN = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        xfer_start = 1'b0;
    logic [31:0] addr = '0;
    logic        rd_nwr = 1'b0;
    logic        card_ack_n = 1'b1;
    logic        card_err_n = 1'b1;
    logic        mb_ack_n = 1'b1;
    logic        mb_start, mb_cancel, mb_commit, mb_drive_en;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    bus_claim_window u0 (
        .clk (clk), .rst_n (rst_n), .xfer_start (xfer_start), .addr (addr),
        .rd_nwr (rd_nwr), .card_ack_n (card_ack_n), .card_err_n (card_err_n),
        .mb_ack_n (mb_ack_n), .mb_start (mb_start), .mb_cancel (mb_cancel),
        .mb_commit (mb_commit), .mb_drive_en (mb_drive_en)
    );

    function automatic int outs();
        return {28'd0, mb_start, mb_cancel, mb_commit, mb_drive_en};
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Drive a card response of kind (1 ack, 2 err, 3 both) for the current cycle.
    task automatic card_rsp(input int kind);
        card_ack_n = !kind[0];
        card_err_n = !kind[1];
    endtask

    // One legacy transfer; card answers in cycle k with the given kind.
    task automatic run_case(input bit rd, input int kind, input int k);
        @(negedge clk);
        xfer_start = 1'b1; addr = 32'hFFFF_820E; rd_nwr = rd;
        @(negedge clk);
        xfer_start = 1'b0;
        chk(mb_start == 1'b1, "R1 start pulse", mb_start, 1);
        for (int c = 1; c <= 12; c++) begin
            if (c == k) card_rsp(kind);
            if (c == 2) begin
                xfer_start = 1'b1; addr = 32'h0000_8000;
            end
            @(negedge clk);
            card_ack_n = 1'b1; card_err_n = 1'b1; xfer_start = 1'b0;
            if (c == 2 && k > 2)
                chk(mb_start == 1'b0, "R10 busy start dropped", mb_start, 0);
            if (c == k && k <= WIN) begin
                chk(outs() == 4, $sformatf("R3 R4 R5 cancel k=%0d kind=%0d", k, kind), outs(), 4);
                break;
            end
            if (c == WIN)
                chk(outs() == (2 + rd), $sformatf("R5 R6 commit rd=%0d", rd), outs(), 2 + rd);
            if (c == k && k > WIN)
                chk(outs() == (2 + rd), $sformatf("R7 late response k=%0d", k), outs(), 2 + rd);
            if (c >= k && c >= WIN) break;
        end
        if (k > WIN) begin
            mb_ack_n = 1'b0;
            @(negedge clk);
            mb_ack_n = 1'b1;
            chk(outs() == 0, "R8 motherboard ack ends", outs(), 0);
        end else begin
            @(negedge clk);
            chk(outs() == 0, "R3 cancel single cycle", outs(), 0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(outs() == 0, "R11 reset state", outs(), 0);
        rst_n = 1'b1;

        // Page sweep: only 0x00 and 0xFF start an access.
        for (int b = 0; b < 256; b++) begin
            bit legacy;
            legacy = (b == 0) || (b == 255);
            @(negedge clk);
            xfer_start = 1'b1; addr = {b[7:0], 24'h12_3456}; rd_nwr = 1'b1;
            @(negedge clk);
            xfer_start = 1'b0;
            chk(mb_start == legacy, $sformatf("R1 R2 page %0d", b), mb_start, legacy);
            card_rsp(1);
            @(negedge clk);
            card_ack_n = 1'b1;
            chk(outs() == (legacy ? 4 : 0), $sformatf("R2 R3 page %0d response", b),
                outs(), legacy ? 4 : 0);
        end

        // Response cycle sweep over direction and response kind.
        for (int rd = 0; rd < 2; rd++)
            for (int kind = 1; kind <= 3; kind++)
                for (int k = 1; k <= 9; k++)
                    run_case(rd[0], kind, k);

        // Back-to-back: start on the edge right after a cancel.
        @(negedge clk);
        xfer_start = 1'b1; addr = 32'h00FF_0000; rd_nwr = 1'b0;
        @(negedge clk);
        xfer_start = 1'b0; card_rsp(3);
        @(negedge clk);
        card_ack_n = 1'b1; card_err_n = 1'b1;
        chk(mb_cancel == 1'b1, "R4 retry cancels", mb_cancel, 1);
        xfer_start = 1'b1; addr = 32'hFF00_0000;
        @(negedge clk);
        xfer_start = 1'b0;
        chk(mb_start == 1'b1, "R9 start after cancel", mb_start, 1);
        repeat (WIN) @(negedge clk);
        chk(mb_commit == 1'b1, "R5 commit", mb_commit, 1);
        mb_ack_n = 1'b0;
        @(negedge clk);
        mb_ack_n = 1'b1; xfer_start = 1'b1; addr = 32'h0000_0010;
        @(negedge clk);
        xfer_start = 1'b0;
        chk(mb_start == 1'b1, "R9 start after motherboard ack", mb_start, 1);

        // Reset in the middle of a window.
        rst_n = 1'b0;
        @(negedge clk);
        chk(outs() == 0, "R11 reset mid-window", outs(), 0);
        rst_n = 1'b1;
        repeat (WIN + 2) @(negedge clk);
        chk(outs() == 0, "R11 idle after reset", outs(), 0);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                n_run++; n_fail++;
                $display("FAIL watchdog actual=0 expected=1");
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule